// File: doc/BRIEF.md
# Memory Error Capture and Reporting Unit

This unit sits beside a memory controller and keeps a record of the first bus error that occurs after software last cleared it. Memory and bus logic present a one-cycle event that carries the failing word address, the requesting agent (processor or DMA), the direction, whether the fault was an ECC failure or a timeout/overrun, and per-bank syndrome information for the two interleaved memory banks. The unit latches that event into an error-address register and a syndrome register. It raises a level interrupt that stays high until software writes the error-address register.

For ECC failures on reads, the captured address is deliberately advanced by five words inside its 4 KiB word window, to match the skew of the memory pipeline. Software removes this offset. A control register holds the ECC mode bits, which come out of reset in normal mode with correction enabled. Combinational status outputs give the event class and say whether the syndrome of the bank holding the failing word points at a check bit.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, the error-address register (select 0) and the syndrome register (select 1) read 0, `irq` is 0, `err_kind` is 0, and the control register (select 2) reads 4 (correction set, both diagnostic bits clear).
- R2: An event that arrives with no capture pending is latched at the next clock edge. Select 0 then reads bit 31 = 1 (valid), bit 30 = agent (1 = CPU), bit 29 = direction (1 = write), bit 28 = ECC flag, bit 27 = overflow, and bits 26:0 = word address.
- R3: For an event with the ECC flag set and direction read, the captured address equals the event address with its low 12 bits increased by 5 modulo 4096, and its upper bits unchanged. All other events are captured without any offset.
- R4: While a capture is pending, further events leave the captured fields unchanged and set the overflow bit (bit 27).
- R5: Any write to select 0, whatever the data, clears both capture registers to 0, clears the overflow bit and drops `irq`.
- R6: If an event arrives in the same cycle as a write to select 0, the event is captured and the overflow bit reads 0.
- R7: Select 1 holds the low-bank half in bits 15:0 and the high-bank half in bits 31:16. In each half, bit 15 is valid, bit 14 is single-bit, bits 6:0 are the syndrome, and the remaining bits are 0. For events without the ECC flag, both halves read 0.
- R8: Writes to select 2 load bit 0 (diagnostic check), bit 1 (diagnostic generate) and bit 2 (correction). These bits read back in place, with all other bits 0, and drive `mode_diag_chk`, `mode_diag_gen` and `mode_correct`.
- R9: Writes to select 1 have no effect on its contents.
- R10: `err_kind` is 0 with no capture pending. With a capture pending it is 1 for an ECC error, 2 for a CPU timeout (ECC flag clear, agent CPU) and 3 for a DMA overrun (ECC flag clear, agent DMA).
- R11: `chk_bit_err` is 1 exactly when a captured ECC error's bank half is valid and its syndrome has exactly one bit set. The bank is chosen by bit 0 of the failing word address (byte-address bit 2): 0 selects the low half and 1 selects the high half.
- R12: `irq` equals the valid flag of the error-address register in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Error event strobe, one cycle |
| evt_addr | input | ADDR_W | Failing word address |
| evt_cpu | input | 1 | 1 = CPU agent, 0 = DMA |
| evt_write | input | 1 | 1 = write, 0 = read |
| evt_ecc | input | 1 | 1 = ECC error, 0 = timeout/overrun |
| evt_lo_vld | input | 1 | Low-bank syndrome valid |
| evt_lo_sngl | input | 1 | Low-bank single-bit judgement |
| evt_lo_syn | input | 7 | Low-bank syndrome |
| evt_hi_vld | input | 1 | High-bank syndrome valid |
| evt_hi_sngl | input | 1 | High-bank single-bit judgement |
| evt_hi_syn | input | 7 | High-bank syndrome |
| reg_sel | input | 2 | Register select: 0 error address, 1 syndrome, 2 control |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level interrupt |
| err_kind | output | 2 | Event class of the pending capture |
| chk_bit_err | output | 1 | Selected-bank syndrome marks a check bit |
| mode_diag_chk | output | 1 | Diagnostic check enable |
| mode_diag_gen | output | 1 | Diagnostic generate enable |
| mode_correct | output | 1 | Correction enable |

## Verification
The bench sweeps every agent, direction and class combination across addresses whose low 12 bits straddle the 4 KiB wrap. A design that carried the skew into the upper bits, or applied it to writes or to non-ECC events, would report the wrong address. It sweeps all 128 syndromes through both banks on skewed and unskewed captures, which catches bank selection taken from the skewed address instead of the failing one. It also drives a second event into a pending capture, and an event in the same cycle as a clear. A design that overwrote the first capture, lost the new error, or kept a stale overflow bit would fail there.

// File: rtl/ecc_cap_pkg.sv
// Shared types and field positions for the memory error capture unit.
// Assumes a 32-bit register bus and two interleaved memory banks.
package ecc_cap_pkg;

    localparam int REG_W    = 32;
    localparam int SYN_W    = 7;
    localparam int HALF_W   = 16;
    localparam int N_BANKS  = 2;

    // Error-address word flag positions
    localparam int EA_VALID = 31;
    localparam int EA_CPU   = 30;
    localparam int EA_WRITE = 29;
    localparam int EA_ECC   = 28;
    localparam int EA_OVF   = 27;

    // Register selects
    localparam logic [1:0] SEL_EADDR = 2'd0;
    localparam logic [1:0] SEL_SYN   = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    typedef struct packed {
        logic             vld;
        logic             sngl;
        logic [SYN_W-1:0] syn;
    } bank_syn_t;

    typedef enum logic [1:0] {
        KIND_NONE    = 2'd0,
        KIND_ECC     = 2'd1,
        KIND_TIMEOUT = 2'd2,
        KIND_OVERRUN = 2'd3
    } err_kind_e;

    // Lay out one bank half: valid at 15, single at 14, syndrome at 6:0
    function automatic logic [HALF_W-1:0] pack_half(bank_syn_t h);
        logic [HALF_W-1:0] w;
        w = '0;
        w[15] = h.vld;
        w[14] = h.sngl;
        w[SYN_W-1:0] = h.syn;
        return w;
    endfunction

endpackage

// File: rtl/ecc_addr_skew.sv
// Applies the read-pipeline skew to a word address: when apply is set, the
// low WIN_W bits advance by SKEW modulo 2**WIN_W and the upper bits pass
// through untouched. Assumes ADDR_W >= WIN_W.
module ecc_addr_skew #(
    parameter int ADDR_W = 27,
    parameter int WIN_W  = 12,
    parameter int SKEW   = 5
) (
    input  logic              apply,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    logic [WIN_W-1:0] win_sum;

    // Offset inside the window; the carry out is dropped on purpose
    always_comb win_sum = addr_in[WIN_W-1:0] + WIN_W'(SKEW);

    generate
        if (ADDR_W > WIN_W) begin : g_upper
            // Keep upper bits, replace window bits when skew applies
            always_comb addr_out = apply ? {addr_in[ADDR_W-1:WIN_W], win_sum} : addr_in;
        end else begin : g_flat
            // Address fits inside one window
            always_comb addr_out = apply ? win_sum : addr_in;
        end
    endgenerate
endmodule

// File: rtl/ecc_capture_core.sv
// Holds the captured event: flags, address, overflow and both syndrome halves.
// First event after a clear is latched; later ones only set overflow.
// A capture in the same cycle as a clear takes precedence.
module ecc_capture_core
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [ADDR_W-1:0] evt_addr_skewed,
    input  logic              evt_cpu,
    input  logic              evt_write,
    input  logic              evt_ecc,
    input  bank_syn_t         evt_banks [N_BANKS],
    input  logic              clr,
    output logic              cap_valid,
    output logic              cap_cpu,
    output logic              cap_write,
    output logic              cap_ecc,
    output logic              cap_ovf,
    output logic [ADDR_W-1:0] cap_addr,
    output bank_syn_t         cap_banks [N_BANKS]
);
    logic take;
    logic drop;

    // Accept when idle or when software is clearing in this same cycle
    always_comb take = evt_valid && (!cap_valid || clr);
    // A pending capture that is not being cleared loses the new event
    always_comb drop = evt_valid && cap_valid && !clr;

    // Capture flags and address, clear on software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_cpu   <= 1'b0;
            cap_write <= 1'b0;
            cap_ecc   <= 1'b0;
            cap_addr  <= '0;
        end else if (take) begin
            cap_valid <= 1'b1;
            cap_cpu   <= evt_cpu;
            cap_write <= evt_write;
            cap_ecc   <= evt_ecc;
            cap_addr  <= evt_addr_skewed;
        end else if (clr) begin
            cap_valid <= 1'b0;
            cap_cpu   <= 1'b0;
            cap_write <= 1'b0;
            cap_ecc   <= 1'b0;
            cap_addr  <= '0;
        end
    end

    // Sticky record of dropped events, reset by a clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cap_ovf <= 1'b0;
        else if (drop)     cap_ovf <= 1'b1;
    end

    generate
        for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
            // Per-bank syndrome half, kept only for ECC events
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cap_banks[b] <= '0;
                else if (take)
                    cap_banks[b] <= evt_ecc ? evt_banks[b] : '0;
                else if (clr)
                    cap_banks[b] <= '0;
            end
        end
    endgenerate
endmodule

// File: rtl/ecc_ctrl_reg.sv
// ECC mode register: diagnostic check, diagnostic generate and correction
// enables. Resets to normal mode (diagnostics off, correction on).
module ecc_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wdata,
    output logic       diag_chk,
    output logic       diag_gen,
    output logic       correct
);
    // Load the three mode bits on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diag_chk <= 1'b0;
            diag_gen <= 1'b0;
            correct  <= 1'b1;
        end else if (wr_en) begin
            diag_chk <= wdata[0];
            diag_gen <= wdata[1];
            correct  <= wdata[2];
        end
    end
endmodule

// File: rtl/ecc_syn_status.sv
// Decodes whether the syndrome of the selected bank names a check bit
// (exactly one syndrome bit set). Purely combinational.
module ecc_syn_status
    import ecc_cap_pkg::*;
(
    input  bank_syn_t  banks [N_BANKS],
    input  logic [$clog2(N_BANKS)-1:0] bank_sel,
    input  logic       ecc_pending,
    output logic       chk_bit
);
    logic [N_BANKS-1:0] single_one;

    generate
        for (genvar b = 0; b < N_BANKS; b++) begin : g_dec
            // One-hot syndrome with the half marked valid
            always_comb single_one[b] = banks[b].vld && ($countones(banks[b].syn) == 1);
        end
    endgenerate

    // Pick the bank that held the failing word
    always_comb chk_bit = ecc_pending && single_one[bank_sel];
endmodule

// File: rtl/ecc_err_capture.sv
// Top of the memory error capture unit. Applies the read skew, captures the
// first event, exposes three registers on a simple bus and derives the
// interrupt and status outputs. Assumes ADDR_W between 12 and 27.
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic              evt_cpu,
    input  logic              evt_write,
    input  logic              evt_ecc,
    input  logic              evt_lo_vld,
    input  logic              evt_lo_sngl,
    input  logic [6:0]        evt_lo_syn,
    input  logic              evt_hi_vld,
    input  logic              evt_hi_sngl,
    input  logic [6:0]        evt_hi_syn,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic [1:0]        err_kind,
    output logic              chk_bit_err,
    output logic              mode_diag_chk,
    output logic              mode_diag_gen,
    output logic              mode_correct
);
    localparam int PAD_W = EA_OVF - ADDR_W;

    logic              skew_on;
    logic [ADDR_W-1:0] addr_skewed;
    bank_syn_t         evt_banks [N_BANKS];
    bank_syn_t         cap_banks [N_BANKS];
    logic              clr_pulse;
    logic              ctrl_wr;
    logic              cap_valid, cap_cpu, cap_write, cap_ecc, cap_ovf;
    logic [ADDR_W-1:0] cap_addr;
    logic [31:0]       eaddr_word;
    logic [31:0]       syn_word;
    logic              bank_sel;

    // Skew applies to ECC failures on reads only
    always_comb skew_on = evt_ecc && !evt_write;

    // Gather bank inputs into an array
    always_comb begin
        evt_banks[0] = '{vld: evt_lo_vld, sngl: evt_lo_sngl, syn: evt_lo_syn};
        evt_banks[1] = '{vld: evt_hi_vld, sngl: evt_hi_sngl, syn: evt_hi_syn};
    end

    // Decode register writes
    always_comb begin
        clr_pulse = reg_wr && (reg_sel == SEL_EADDR);
        ctrl_wr   = reg_wr && (reg_sel == SEL_CTRL);
    end

    ecc_addr_skew #(.ADDR_W(ADDR_W), .WIN_W(12), .SKEW(5)) u_skew (
        .apply    (skew_on),
        .addr_in  (evt_addr),
        .addr_out (addr_skewed)
    );

    ecc_capture_core #(.ADDR_W(ADDR_W)) u_core (
        .clk             (clk),
        .rst_n           (rst_n),
        .evt_valid       (evt_valid),
        .evt_addr_skewed (addr_skewed),
        .evt_cpu         (evt_cpu),
        .evt_write       (evt_write),
        .evt_ecc         (evt_ecc),
        .evt_banks       (evt_banks),
        .clr             (clr_pulse),
        .cap_valid       (cap_valid),
        .cap_cpu         (cap_cpu),
        .cap_write       (cap_write),
        .cap_ecc         (cap_ecc),
        .cap_ovf         (cap_ovf),
        .cap_addr        (cap_addr),
        .cap_banks       (cap_banks)
    );

    ecc_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr),
        .wdata    (reg_wdata[2:0]),
        .diag_chk (mode_diag_chk),
        .diag_gen (mode_diag_gen),
        .correct  (mode_correct)
    );

    // Skewed read captures have bit 0 flipped (offset 5 is odd): undo it
    always_comb bank_sel = cap_addr[0] ^ (cap_ecc && !cap_write);

    ecc_syn_status u_stat (
        .banks       (cap_banks),
        .bank_sel    (bank_sel),
        .ecc_pending (cap_valid && cap_ecc),
        .chk_bit     (chk_bit_err)
    );

    // Assemble readable register words
    always_comb begin
        eaddr_word = {cap_valid, cap_cpu, cap_write, cap_ecc, cap_ovf,
                      {PAD_W{1'b0}}, cap_addr};
        syn_word   = {pack_half(cap_banks[1]), pack_half(cap_banks[0])};
    end

    // Register read mux
    always_comb begin
        case (reg_sel)
            SEL_EADDR: reg_rdata = eaddr_word;
            SEL_SYN:   reg_rdata = syn_word;
            SEL_CTRL:  reg_rdata = {29'd0, mode_correct, mode_diag_gen, mode_diag_chk};
            default:   reg_rdata = '0;
        endcase
    end

    // Level interrupt follows the valid flag
    always_comb irq = cap_valid;

    // Classify the pending event
    always_comb begin
        if (!cap_valid)   err_kind = KIND_NONE;
        else if (cap_ecc) err_kind = KIND_ECC;
        else if (cap_cpu) err_kind = KIND_TIMEOUT;
        else              err_kind = KIND_OVERRUN;
    end
endmodule

// File: rtl/ecc_err_capture_chk.sv
// Temporal checks on the capture unit, bound into every instance.
module ecc_err_capture_chk #(
    parameter int ADDR_W = 27
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_valid,
    input logic              evt_write,
    input logic              evt_ecc,
    input logic [ADDR_W-1:0] evt_addr,
    input logic              clr_pulse,
    input logic              irq,
    input logic              cap_ovf,
    input logic [ADDR_W-1:0] cap_addr,
    input logic [31:0]       syn_word
);
    // R2: an accepted event raises the interrupt next cycle
    p_capture_sets_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !irq |=> irq);

    // R3: skewed read-ECC address in the 12-bit window
    p_read_skew_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !irq && evt_ecc && !evt_write
        |=> cap_addr[11:0] == ($past(evt_addr[11:0]) + 12'd5));

    // R4: a pending capture holds its address and flags overflow
    p_hold_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && irq && !clr_pulse |=> $stable(cap_addr) && cap_ovf);

    // R5: a clear with no event drops the interrupt
    p_clear_drops_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse && !evt_valid |=> !irq && !cap_ovf);

    // R6: capture wins over a simultaneous clear
    p_capture_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse && evt_valid |=> irq && !cap_ovf);

    // R9: syndrome word only moves on capture or clear
    p_syn_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_valid && (!irq || clr_pulse)) && !clr_pulse |=> $stable(syn_word));
endmodule

bind ecc_err_capture ecc_err_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_write (evt_write),
    .evt_ecc   (evt_ecc),
    .evt_addr  (evt_addr),
    .clr_pulse (clr_pulse),
    .irq       (irq),
    .cap_ovf   (cap_ovf),
    .cap_addr  (cap_addr),
    .syn_word  (syn_word)
);

// File: tb/tb_ecc_err_capture.sv
module tb_ecc_err_capture;
    localparam int AW = 27;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evt_valid = 1'b0;
    logic [AW-1:0] evt_addr = '0;
    logic          evt_cpu = 1'b0, evt_write = 1'b0, evt_ecc = 1'b0;
    logic          evt_lo_vld = 1'b0, evt_lo_sngl = 1'b0;
    logic [6:0]    evt_lo_syn = '0;
    logic          evt_hi_vld = 1'b0, evt_hi_sngl = 1'b0;
    logic [6:0]    evt_hi_syn = '0;
    logic [1:0]    reg_sel = 2'd0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;
    logic [1:0]    err_kind;
    logic          chk_bit_err;
    logic          mode_diag_chk, mode_diag_gen, mode_correct;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ecc_err_capture #(.ADDR_W(AW)) dut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_evt(logic [AW-1:0] a, logic c, logic w, logic e,
                           logic [8:0] lo, logic [8:0] hi);
        evt_addr = a; evt_cpu = c; evt_write = w; evt_ecc = e;
        {evt_lo_vld, evt_lo_sngl, evt_lo_syn} = lo;
        {evt_hi_vld, evt_hi_sngl, evt_hi_syn} = hi;
    endtask

    task automatic fire(logic [AW-1:0] a, logic c, logic w, logic e,
                        logic [8:0] lo, logic [8:0] hi);
        @(negedge clk);
        set_evt(a, c, w, e, lo, hi);
        evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] a, logic w, logic e);
        if (e && !w) return {a[AW-1:12], a[11:0] + 12'd5};
        return a;
    endfunction

    function automatic logic [31:0] exp_ea(logic [AW-1:0] a, logic c, logic w,
                                           logic e, logic ovf);
        return {1'b1, c, w, e, ovf, exp_addr(a, w, e)};
    endfunction

    function automatic logic [15:0] half(logic [8:0] h);
        return {h[8], h[7], 7'd0, h[6:0]};
    endfunction

    function automatic logic [1:0] exp_kind(logic c, logic e);
        return e ? 2'd1 : (c ? 2'd2 : 2'd3);
    endfunction

    // Watchdog: an expired run counts as a failure and still reports
    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); check("R1 eaddr", d, 0);
        rd(2'd1, d); check("R1 syn", d, 0);
        rd(2'd2, d); check("R1 ctrl", d, 32'd4);
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 kind", {30'd0, err_kind}, 0);

        // R2 R3 R7 R10 R11 R12 sweep over classes and wrap addresses
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < 8; i++) begin
                logic c, w, e;
                logic [AW-1:0] a;
                logic [8:0] lo, hi;
                logic exp_chk;
                {c, w, e} = 3'(k);
                a = {15'(i * 4099 + k * 31), 12'hFFA + 12'(i)};
                lo = {i[0], i[1], 7'(i * 13 + k)};
                hi = {i[1] | i[2], i[0], 7'(1 << (i % 7))};
                fire(a, c, w, e, lo, hi);
                rd(2'd0, d); check("R2 R3 eaddr", d, exp_ea(a, c, w, e, 1'b0));
                rd(2'd1, d);
                check("R7 syn", d, e ? {half(hi), half(lo)} : 32'd0);
                check("R12 irq", {31'd0, irq}, 1);
                check("R10 kind", {30'd0, err_kind}, {30'd0, exp_kind(c, e)});
                exp_chk = e && (a[0] ? (hi[8] && $countones(hi[6:0]) == 1)
                                     : (lo[8] && $countones(lo[6:0]) == 1));
                check("R11 chkbit", {31'd0, chk_bit_err}, {31'd0, exp_chk});
                wr(2'd0, 32'(i * 7919 + k));
                rd(2'd0, d); check("R5 eaddr cleared", d, 0);
                rd(2'd1, d); check("R5 syn cleared", d, 0);
                check("R5 irq", {31'd0, irq}, 0);
                check("R10 kind none", {30'd0, err_kind}, 0);
            end
        end

        // R11 all syndromes, both banks, skewed read and unskewed write
        for (int s = 0; s < 128; s++) begin
            for (int m = 0; m < 4; m++) begin
                logic [AW-1:0] a;
                logic [8:0] lo, hi;
                logic exp_chk;
                a = {15'(s), 12'hFFC + 12'(m)};
                lo = (m[0] == 1'b0) ? {2'b10, 7'(s)} : {2'b10, 7'h7F};
                hi = (m[0] == 1'b1) ? {2'b10, 7'(s)} : {2'b10, 7'h7F};
                fire(a, 1'b1, m[1], 1'b1, lo, hi);
                exp_chk = ($countones(7'(s)) == 1);
                check("R11 syn sweep", {31'd0, chk_bit_err}, {31'd0, exp_chk});
                wr(2'd0, 32'hFFFF_FFFF);
            end
        end

        // R4 second event dropped, overflow set
        fire(27'h123_4567, 1'b1, 1'b1, 1'b0, 9'd0, 9'd0);
        fire(27'h765_4321, 1'b0, 1'b0, 1'b1, 9'h1FF, 9'h1FF);
        rd(2'd0, d); check("R4 first kept", d, exp_ea(27'h123_4567, 1'b1, 1'b1, 1'b0, 1'b1));
        rd(2'd1, d); check("R4 syn kept", d, 0);

        // R9 writes to syndrome register ignored
        wr(2'd0, 0);
        fire(27'h000_0ABC, 1'b0, 1'b0, 1'b1, {2'b11, 7'h15}, {2'b01, 7'h40});
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); check("R9 syn unchanged", d, {half({2'b01, 7'h40}), half({2'b11, 7'h15})});

        // R6 event and clear in the same cycle: event wins, overflow cleared
        fire(27'h0AA_0AAA, 1'b1, 1'b0, 1'b0, 9'd0, 9'd0);
        @(negedge clk);
        set_evt(27'h055_0555, 1'b0, 1'b1, 1'b0, 9'd0, 9'd0);
        evt_valid = 1'b1; reg_sel = 2'd0; reg_wr = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0; reg_wr = 1'b0;
        rd(2'd0, d); check("R6 capture wins", d, exp_ea(27'h055_0555, 1'b0, 1'b1, 1'b0, 1'b0));
        check("R6 irq", {31'd0, irq}, 1);
        wr(2'd0, 0);

        // R8 control register all values
        for (int v = 0; v < 8; v++) begin
            wr(2'd2, 32'hFFFF_FFF8 | 32'(v));
            rd(2'd2, d); check("R8 ctrl readback", d, 32'(v));
            check("R8 mode pins", {29'd0, mode_correct, mode_diag_gen, mode_diag_chk}, 32'(v));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule